// File: doc/BRIEF.md
# Device Power State Control Register

This block is the power management control and status word of a configuration-space function. Software reads and writes it as one 32-bit word at a single configuration address. It holds the device power state, either fully on (D0) or suspended (D3hot). It also holds a keep-context option and a pair of wake bits: an enable and a sticky status flag. While the function is suspended, its I/O and memory decode enables and its interrupt enable are driven low. Configuration accesses keep working in that state.

A software move from D3hot back to D0 produces a one-cycle internal soft reset pulse, unless the keep-context bit is set. An external lock input can freeze the keep-context bit. The wake status flag is set by the function's wake event whatever the enable holds. A wake request goes out while the flag and the enable are both set. The two wake bits and the wake request sit in an always-on domain. Only the resume reset clears them; the main reset and the soft reset leave them alone.

Top module: `pwr_state_csr`

## Requirements
- R1: After the main reset and the resume reset, the state is D0 (code 00) and keep-context is 1. Decode and interrupt enables are 1, the soft reset output is 0, and a read returns 32'h0000_0008.
- R2: A write with byte lane 0 enabled and bits 1:0 equal to 00 (D0) or 11 (D3hot) sets the power state, and the new state is readable.
- R3: A write of 01 or 10 to bits 1:0 completes but leaves the power state unchanged.
- R4: The I/O-memory decode enable and the interrupt enable are 1 in D0 and 0 in D3hot, and they change on the same edge as the state. Reads still return the register while in D3hot.
- R5: A write that moves the state from D3hot to D0 while keep-context (bit 3, value before the write) is 0 drives soft_rst_o high for exactly the one cycle after that write's edge. No pulse follows when keep-context is 1, and no pulse follows a write that leaves the state unchanged.
- R6: Keep-context (bit 3) takes the written value when the lock input is low. It keeps its value when the lock input is high.
- R7: Wake status (bit 15) is set by wake_evt whatever the enable holds. Writing 1 to it clears it, writing 0 has no effect, and a wake event in the same cycle as the clearing write leaves it set.
- R8: Wake enable is bit 8. pme_req_o is 1 exactly when wake enable and wake status are both 1, and it updates on the edge that changes either bit.
- R9: The main reset leaves wake enable and wake status unchanged. Only the resume reset clears them.
- R10: Bits 31:16, 14:9, 7:4 and 2 always read as 0, even after a write of all ones.
- R11: Byte lane 0 controls bits 1:0 and bit 3, and byte lane 1 controls bits 8 and 15. A write without a lane leaves that lane's fields unchanged.
- R12: Writes to any other address change nothing, and reads of any other address return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Main synchronous reset, active high |
| rst_resume | input | 1 | Always-on domain synchronous reset, active high |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | ADDR_W | Configuration word address |
| cfg_be | input | DW/8 | Write byte enables |
| cfg_wdata | input | DW | Write data |
| cfg_rdata | output | DW | Read data, valid the cycle after cfg_rd, 0 otherwise |
| keep_ctx_lock | input | 1 | Freezes the keep-context bit when high |
| wake_evt | input | 1 | Function wake event |
| pwr_state_o | output | 2 | Current power state code |
| io_mem_en_o | output | 1 | I/O and memory decode enable |
| irq_en_o | output | 1 | Interrupt enable |
| soft_rst_o | output | 1 | One-cycle internal soft reset pulse |
| pme_req_o | output | 1 | Wake request |

## Verification
Every result is registered once. A write, a wake event or a reset sampled at one rising edge shows up in the state, the enables, the soft reset pulse and the wake request right after that same edge. Read data is also captured at the edge where cfg_rd is sampled, and it shows the register contents from before any write in that same cycle. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares every output at the next falling edge, so each result is checked in the cycle it becomes due. The soft reset pulse is checked both high in that cycle and low one cycle later.

// File: rtl/pwr_state_pkg.sv
`timescale 1ns/1ps
package pwr_state_pkg;
  localparam logic [1:0] PS_ON  = 2'b00;
  localparam logic [1:0] PS_OFF = 2'b11;

  localparam int PS_LSB   = 0;
  localparam int KEEP_BIT = 3;
  localparam int EN_BIT   = 8;
  localparam int STS_BIT  = 15;

  function automatic logic ps_legal(input logic [1:0] code);
    return (code == PS_ON) || (code == PS_OFF);
  endfunction
endpackage

// File: rtl/pwr_state_core.sv
`timescale 1ns/1ps
module pwr_state_core
  import pwr_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lane_wr,
  input  logic [1:0] req_ps,
  input  logic       keep_wd,
  input  logic       keep_lock,
  output logic [1:0] state_o,
  output logic       keep_o,
  output logic       soft_rst_o,
  output logic       io_mem_en_o,
  output logic       irq_en_o
);
  logic [1:0] state_q, state_nx;
  logic       keep_q;
  logic       wake_up;

  always_comb begin
    state_nx = state_q;
    if (lane_wr && ps_legal(req_ps)) state_nx = req_ps;
    wake_up = (state_q == PS_OFF) && (state_nx == PS_ON) && !keep_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PS_ON;
      keep_q      <= 1'b1;
      soft_rst_o  <= 1'b0;
      io_mem_en_o <= 1'b1;
      irq_en_o    <= 1'b1;
    end else begin
      state_q     <= state_nx;
      if (lane_wr && !keep_lock) keep_q <= keep_wd;
      soft_rst_o  <= wake_up;
      io_mem_en_o <= (state_nx == PS_ON);
      irq_en_o    <= (state_nx == PS_ON);
    end
  end

  assign state_o = state_q;
  assign keep_o  = keep_q;
endmodule

// File: rtl/pwr_wake_regs.sv
`timescale 1ns/1ps
module pwr_wake_regs (
  input  logic clk,
  input  logic rst_resume,
  input  logic lane_wr,
  input  logic en_wd,
  input  logic clr_wd,
  input  logic wake_evt,
  output logic en_o,
  output logic sts_o,
  output logic pme_req_o
);
  logic en_q, sts_q, en_nx, sts_nx;

  always_comb begin
    en_nx  = lane_wr ? en_wd : en_q;
    sts_nx = sts_q;
    if (lane_wr && clr_wd) sts_nx = 1'b0;
    if (wake_evt)          sts_nx = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_resume) begin
      en_q      <= 1'b0;
      sts_q     <= 1'b0;
      pme_req_o <= 1'b0;
    end else begin
      en_q      <= en_nx;
      sts_q     <= sts_nx;
      pme_req_o <= en_nx & sts_nx;
    end
  end

  assign en_o  = en_q;
  assign sts_o = sts_q;
endmodule

// File: rtl/pwr_read_mux.sv
`timescale 1ns/1ps
module pwr_read_mux
  import pwr_state_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_hit,
  input  logic [1:0]    state,
  input  logic          keep,
  input  logic          en,
  input  logic          sts,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] word;

  always_comb begin
    word                 = '0;
    word[PS_LSB+1:PS_LSB] = state;
    word[KEEP_BIT]       = keep;
    word[EN_BIT]         = en;
    word[STS_BIT]        = sts;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_hit ? word : '0;
  end
endmodule

// File: rtl/pwr_state_csr.sv
`timescale 1ns/1ps
module pwr_state_csr
  import pwr_state_pkg::*;
#(
  parameter int              ADDR_W   = 8,
  parameter int              DW       = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 8'h40
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_resume,
  input  logic              cfg_wr,
  input  logic              cfg_rd,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW/8-1:0]   cfg_be,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [DW-1:0]     cfg_rdata,
  input  logic              keep_ctx_lock,
  input  logic              wake_evt,
  output logic [1:0]        pwr_state_o,
  output logic              io_mem_en_o,
  output logic              irq_en_o,
  output logic              soft_rst_o,
  output logic              pme_req_o
);
  localparam int BE_W = DW / 8;

  logic            addr_hit;
  logic            wr_hit;
  logic            rd_hit;
  logic [BE_W-1:0] lane_wr;
  logic            keep_q_w;
  logic            pme_en_w;
  logic            pme_sts_w;
  logic            unused_wd;

  assign addr_hit = (cfg_addr == REG_ADDR);
  assign wr_hit   = cfg_wr && addr_hit;
  assign rd_hit   = cfg_rd && addr_hit;

  for (genvar i = 0; i < BE_W; i++) begin : g_lane
    assign lane_wr[i] = wr_hit && cfg_be[i];
  end

  assign unused_wd = ^{cfg_wdata[DW-1:16], cfg_wdata[14:9], cfg_wdata[7:4],
                       cfg_wdata[2], lane_wr[BE_W-1:2]};

  pwr_state_core u_core (
    .clk         (clk),
    .rst         (rst),
    .lane_wr     (lane_wr[0]),
    .req_ps      (cfg_wdata[PS_LSB+1:PS_LSB]),
    .keep_wd     (cfg_wdata[KEEP_BIT]),
    .keep_lock   (keep_ctx_lock),
    .state_o     (pwr_state_o),
    .keep_o      (keep_q_w),
    .soft_rst_o  (soft_rst_o),
    .io_mem_en_o (io_mem_en_o),
    .irq_en_o    (irq_en_o)
  );

  pwr_wake_regs u_wake (
    .clk        (clk),
    .rst_resume (rst_resume),
    .lane_wr    (lane_wr[1]),
    .en_wd      (cfg_wdata[EN_BIT]),
    .clr_wd     (cfg_wdata[STS_BIT]),
    .wake_evt   (wake_evt),
    .en_o       (pme_en_w),
    .sts_o      (pme_sts_w),
    .pme_req_o  (pme_req_o)
  );

  pwr_read_mux #(.DW(DW)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_hit  (rd_hit),
    .state   (pwr_state_o),
    .keep    (keep_q_w),
    .en      (pme_en_w),
    .sts     (pme_sts_w),
    .rdata_o (cfg_rdata)
  );
endmodule

// File: rtl/pwr_state_chk.sv
`timescale 1ns/1ps
module pwr_state_chk (
  input logic       clk,
  input logic       rst,
  input logic       rst_resume,
  input logic       wake_evt,
  input logic       keep_lock,
  input logic [1:0] state,
  input logic       io_en,
  input logic       irq_en,
  input logic       soft_rst,
  input logic       pme_req,
  input logic       keep,
  input logic       pme_en,
  input logic       pme_sts
);
  assert_state_legal_R3: assert property (@(posedge clk) disable iff (rst)
    (state == 2'b00) || (state == 2'b11));

  assert_gate_follows_R4: assert property (@(posedge clk) disable iff (rst)
    (io_en == (state == 2'b00)) && (irq_en == (state == 2'b00)));

  assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> !soft_rst);

  assert_pulse_cause_R5: assert property (@(posedge clk) disable iff (rst)
    soft_rst |-> ($past(state) == 2'b11) && (state == 2'b00));

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
    keep_lock |=> $stable(keep));

  assert_wake_sets_R7: assert property (@(posedge clk) disable iff (rst_resume)
    wake_evt |=> pme_sts);

  assert_req_and_R8: assert property (@(posedge clk) disable iff (rst_resume)
    pme_req == (pme_en && pme_sts));
endmodule

bind pwr_state_csr pwr_state_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .rst_resume(rst_resume),
  .wake_evt  (wake_evt),
  .keep_lock (keep_ctx_lock),
  .state     (pwr_state_o),
  .io_en     (io_mem_en_o),
  .irq_en    (irq_en_o),
  .soft_rst  (soft_rst_o),
  .pme_req   (pme_req_o),
  .keep      (keep_q_w),
  .pme_en    (pme_en_w),
  .pme_sts   (pme_sts_w)
);

// File: tb/tb_pwr_state_csr.sv
`timescale 1ns/1ps
module tb_pwr_state_csr;
  localparam logic [7:0] A = 8'h40;

  logic        clk = 1'b0;
  logic        rst = 1'b1, rst_resume = 1'b1;
  logic        cfg_wr = 0, cfg_rd = 0, keep_ctx_lock = 0, wake_evt = 0;
  logic [7:0]  cfg_addr = A;
  logic [3:0]  cfg_be = 0;
  logic [31:0] cfg_wdata = 0;
  logic [31:0] cfg_rdata;
  logic [1:0]  pwr_state_o;
  logic        io_mem_en_o, irq_en_o, soft_rst_o, pme_req_o;

  always #2.5 clk = ~clk;

  pwr_state_csr dut (.*);

  int checks = 0, errors = 0;
  bit [1:0]  m_state;
  bit        m_keep, m_en, m_sts, m_pulse, m_req;
  bit [31:0] m_rdata;

  function automatic bit [31:0] pack();
    return {16'h0, m_sts, 6'h0, m_en, 4'h0, m_keep, 1'b0, m_state};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    bit [31:0] old = pack();
    bit hw = cfg_wr && (cfg_addr == A);
    bit hr = cfg_rd && (cfg_addr == A);
    bit [1:0] ns = m_state;
    if (rst_resume) begin m_en = 0; m_sts = 0; end
    else begin
      if (hw && cfg_be[1]) begin m_en = cfg_wdata[8]; if (cfg_wdata[15]) m_sts = 0; end
      if (wake_evt) m_sts = 1;
    end
    m_req = m_en & m_sts;
    if (rst) begin m_state = 0; m_keep = 1; m_pulse = 0; m_rdata = 0; end
    else begin
      m_rdata = hr ? old : 32'h0;
      if (hw && cfg_be[0] && (cfg_wdata[1:0] == 2'b00 || cfg_wdata[1:0] == 2'b11))
        ns = cfg_wdata[1:0];
      m_pulse = (m_state == 2'b11) && (ns == 2'b00) && !m_keep;
      if (hw && cfg_be[0] && !keep_ctx_lock) m_keep = cfg_wdata[3];
      m_state = ns;
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R2 state", {30'h0, pwr_state_o}, {30'h0, m_state});
    chk("R4 io_mem_en", {31'h0, io_mem_en_o}, {31'h0, m_state == 2'b00});
    chk("R4 irq_en", {31'h0, irq_en_o}, {31'h0, m_state == 2'b00});
    chk("R5 soft_rst", {31'h0, soft_rst_o}, {31'h0, m_pulse});
    chk("R8 pme_req", {31'h0, pme_req_o}, {31'h0, m_req});
    chk("R10 rdata", cfg_rdata, m_rdata);
    cfg_wr = 0; cfg_rd = 0; wake_evt = 0; cfg_addr = A;
  endtask

  task automatic wr(input logic [3:0] be, input logic [31:0] d);
    cfg_wr = 1; cfg_be = be; cfg_wdata = d; step();
  endtask

  task automatic rd();
    cfg_rd = 1; step();
  endtask

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    step(); step(); step();
    rst = 0; rst_resume = 0;
    rd();
    chk("R1 reset readback", cfg_rdata, 32'h0000_0008);
    chk("R1 soft_rst idle", {31'h0, soft_rst_o}, 32'h0);
    wr(4'hF, 32'h0000_000B);
    chk("R2 enter D3hot", {30'h0, pwr_state_o}, 32'h3);
    chk("R4 decode off", {31'h0, io_mem_en_o}, 32'h0);
    rd();
    chk("R4 config read in D3hot", cfg_rdata, 32'h0000_000B);
    wr(4'hF, 32'h0000_0009);
    chk("R3 code 01 dropped", {30'h0, pwr_state_o}, 32'h3);
    wr(4'hF, 32'h0000_000A);
    chk("R3 code 10 dropped", {30'h0, pwr_state_o}, 32'h3);
    wr(4'hF, 32'h0000_000B);
    chk("R5 same state no pulse", {31'h0, soft_rst_o}, 32'h0);
    wr(4'hF, 32'h0000_0008);
    chk("R5 keep set no pulse", {31'h0, soft_rst_o}, 32'h0);
    wr(4'hF, 32'h0000_0003);
    wr(4'hF, 32'h0000_0000);
    chk("R5 pulse high", {31'h0, soft_rst_o}, 32'h1);
    step();
    chk("R5 pulse gone", {31'h0, soft_rst_o}, 32'h0);
    keep_ctx_lock = 1;
    wr(4'hF, 32'h0000_0008);
    rd();
    chk("R6 locked keep bit", cfg_rdata, 32'h0000_0000);
    keep_ctx_lock = 0;
    wr(4'hF, 32'h0000_0008);
    wake_evt = 1; step();
    rd();
    chk("R7 wake sets status", cfg_rdata, 32'h0000_8008);
    chk("R8 no req without enable", {31'h0, pme_req_o}, 32'h0);
    wr(4'h2, 32'h0000_0100);
    chk("R8 req with enable", {31'h0, pme_req_o}, 32'h1);
    wr(4'h2, 32'h0000_0100);
    chk("R7 write 0 keeps status", {31'h0, pme_req_o}, 32'h1);
    wr(4'h2, 32'h0000_8100);
    chk("R7 write 1 clears", {31'h0, pme_req_o}, 32'h0);
    wake_evt = 1; wr(4'h2, 32'h0000_8100);
    chk("R7 wake beats clear", {31'h0, pme_req_o}, 32'h1);
    rst = 1; step(); rst = 0;
    rd();
    chk("R9 main reset keeps wake bits", cfg_rdata, 32'h0000_8108);
    wr(4'hF, 32'hFFFF_FFFF);
    rd();
    chk("R10 reserved read zero", cfg_rdata, 32'h0000_010B);
    wr(4'hE, 32'h0000_0000);
    rd();
    chk("R11 lane 0 off keeps state", cfg_rdata, 32'h0000_000B);
    wr(4'h1, 32'h0000_8100);
    rd();
    chk("R11 lane 1 off keeps enable", cfg_rdata, 32'h0000_0000);
    cfg_addr = A + 8'h4; wr(4'hF, 32'h0000_0003);
    chk("R12 other address write", {30'h0, pwr_state_o}, 32'h0);
    cfg_addr = A + 8'h4; rd();
    chk("R12 other address read", cfg_rdata, 32'h0);
    for (int i = 0; i < 4000; i++) begin
      int op = $urandom_range(0, 99);
      cfg_addr = ($urandom_range(0, 9) == 0) ? A + 8'h4 : A;
      cfg_be = 4'($urandom);
      cfg_wdata = $urandom;
      keep_ctx_lock = ($urandom_range(0, 3) == 0);
      wake_evt = ($urandom_range(0, 7) == 0);
      rst = (op == 0);
      rst_resume = (op == 1);
      if (op < 50) cfg_wr = 1;
      if (op >= 40 && op < 80) cfg_rd = 1;
      step();
      rst = 0; rst_resume = 0;
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule